// File: doc/BRIEF.md
# Merged Column-Mix and Binary Diffusion Layer

This block is the linear layer of a 128-bit substitution-permutation cipher datapath that serves two cipher families. From one shared XOR network it computes one of four combinational functions of a 16-byte state: the AES column mix, its inverse, a 16×16 binary diffusion matrix in which every output byte is the XOR of seven input bytes, or a plain pass-through. It has no clock and no storage. It sits between the substitution layer and the key addition, and the round controller sets the function select for each round.

The network first forms two sets of byte-pair XOR terms. The first set pairs cyclically adjacent bytes within a column. The second set pairs bytes two rows apart within a column. The column mix is built from the first set. The inverse column mix adds two constant multiples (by {08} and {0C}) of the second set to the column-mix result. Each diffusion byte is one input byte, one two-apart term and two adjacent terms, so most of the diffusion cost is shared with the column functions.

Top module: `perm_merged_layer`

## Requirements
- R1: The state is 128 bits with byte x0 in bits [127:120] and byte x15 in bits [7:0]. Bytes x(4c)..x(4c+3) form column c. With `func_sel` = 2'b00, each column is multiplied by the circulant matrix with first row {02,03,01,01} over GF(2^8) modulo x^8+x^4+x^3+x+1. For example, column db 13 53 45 gives 8e 4d a1 bc.
- R2: With `func_sel` = 2'b01, each column is multiplied by the circulant matrix with first row {0e,0b,0d,09}, so that applying this function to the select-00 result returns the original state.
- R3: With `func_sel` = 2'b10, output byte k is the XOR of seven input bytes given by a fixed symmetric 16×16 binary matrix. For example, y0 = x3^x4^x6^x8^x9^x13^x14 and y15 = x1^x2^x4^x5^x8^x10^x15.
- R4: Under `func_sel` = 2'b10 the function is an involution: applying it twice returns the input.
- R5: With `func_sel` = 2'b11, the output equals the input bit for bit.
- R6: Under selects 00 and 01, the XOR of the four output bytes of each column equals the XOR of that column's four input bytes.
- R7: Under select 10, the XOR of all sixteen output bytes equals the XOR of all sixteen input bytes.
- R8: Under selects 00 and 01, changing the bytes of one input column changes no output byte outside that column.
- R9: Every function is linear over GF(2): f(a^b) = f(a)^f(b), and an all-zero state maps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| func_sel | input | 2 | Function select: 00 column mix, 01 inverse column mix, 10 binary diffusion, 11 pass-through |
| state_in | input | 128 | Input state, byte x0 in the most significant byte |
| state_out | output | 128 | Transformed state, same byte order |

## Verification
The hardest thing to show from the ports is that each of the 128 input bits reaches exactly the right output bits in every mode. A wrong index in the shared pair terms can still give correct results on symmetric or all-equal columns. The bench therefore sweeps every single-bit input under all four selects and compares each result with a matrix model computed from field multiplication and a row-mask table. Random states then exercise linearity, both round trips and the confinement of each column.

// File: rtl/perm_pkg.sv
package perm_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 16;
    localparam int ROWS      = 4;
    localparam int NUM_COLS  = NUM_BYTES / ROWS;
    localparam int NUM_BETA  = NUM_BYTES / 2;
    localparam int STATE_W   = BYTE_W * NUM_BYTES;
    localparam int SEL_W     = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [0:NUM_BYTES-1] state_t;
    typedef byte_t [0:NUM_BETA-1]  beta_t;
    typedef byte_t [0:ROWS-1]      col_t;

    typedef enum logic [SEL_W-1:0] {
        PERM_MIX  = 2'b00,
        PERM_INV  = 2'b01,
        PERM_DIFF = 2'b10,
        PERM_PASS = 2'b11
    } perm_sel_e;

    // low byte of the field polynomial x^8+x^4+x^3+x+1
    localparam byte_t FIELD_RED = 8'h1B;

    // multiply by {02} in the field
    function automatic byte_t xt2(byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? FIELD_RED : '0);
    endfunction

    // index of the byte d rows further down the same column (cyclic)
    function automatic int col_nbr(int i, int d);
        return ROWS * (i / ROWS) + ((i + d) % ROWS);
    endfunction

    // two operands of the j-th two-apart pair term
    function automatic int beta_lo(int j);
        return 2 * j - (j % 2);
    endfunction

    function automatic int beta_hi(int j);
        return 2 * (j + 1) - (j % 2);
    endfunction

    // diffusion byte k = x[SELF] ^ beta[BETA] ^ alpha[ALPHA_A] ^ alpha[ALPHA_B]
    localparam int DIFF_SELF    [NUM_BYTES] = '{3, 2, 1, 0, 5, 4, 7, 6,
                                               10, 11, 8, 9, 12, 13, 14, 15};
    localparam int DIFF_BETA    [NUM_BYTES] = '{2, 3, 2, 3, 0, 1, 0, 1,
                                                7, 6, 7, 6, 5, 4, 5, 4};
    localparam int DIFF_ALPHA_A [NUM_BYTES] = '{8, 8, 10, 10, 11, 9, 9, 11,
                                                0, 0, 2, 2, 1, 3, 3, 1};
    localparam int DIFF_ALPHA_B [NUM_BYTES] = '{13, 15, 15, 13, 14, 14, 12, 12,
                                                7, 5, 5, 7, 6, 6, 4, 4};

endpackage

// File: rtl/perm_pair_xor.sv
module perm_pair_xor
    import perm_pkg::*;
(
    input  state_t x,
    output state_t alpha,
    output beta_t  beta
);

    // adjacent-row pairs: one per byte
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_alpha
        localparam int PARTNER = col_nbr(i, 1);
        assign alpha[i] = x[i] ^ x[PARTNER];
    end

    // two-apart pairs: two per column
    for (genvar j = 0; j < NUM_BETA; j++) begin : g_beta
        localparam int LO = beta_lo(j);
        localparam int HI = beta_hi(j);
        assign beta[j] = x[LO] ^ x[HI];
    end

endmodule

// File: rtl/perm_mix_column.sv
module perm_mix_column
    import perm_pkg::*;
#(
    parameter int COL = 0
) (
    input  state_t x,
    input  state_t alpha,
    input  beta_t  beta,
    output col_t   mix,
    output col_t   inv
);

    localparam int BASE  = ROWS * COL;
    localparam int BBASE = 2 * COL;

    byte_t m4  [2];
    byte_t m8  [2];
    byte_t m12 [2];

    // constant multiples of the two-apart terms, shared by all rows
    for (genvar b = 0; b < 2; b++) begin : g_const
        assign m4[b]  = xt2(xt2(beta[BBASE + b]));
        assign m8[b]  = xt2(m4[b]);
        assign m12[b] = m8[b] ^ m4[b];
    end

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            byte_t u;
            u = x[col_nbr(BASE + r, 1)]
              ^ xt2(alpha[BASE + r])
              ^ alpha[col_nbr(BASE + r, 2)];
            mix[r] = u;
            inv[r] = u ^ m12[r % 2] ^ m8[(r + 1) % 2];
        end
    end

endmodule

// File: rtl/perm_binary_diffuse.sv
module perm_binary_diffuse
    import perm_pkg::*;
(
    input  state_t x,
    input  state_t alpha,
    input  beta_t  beta,
    output state_t w
);

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_row
        localparam int SI = DIFF_SELF[k];
        localparam int BI = DIFF_BETA[k];
        localparam int AA = DIFF_ALPHA_A[k];
        localparam int AB = DIFF_ALPHA_B[k];
        assign w[k] = x[SI] ^ beta[BI] ^ alpha[AA] ^ alpha[AB];
    end

endmodule

// File: rtl/perm_merged_layer.sv
module perm_merged_layer
    import perm_pkg::*;
(
    input  logic [SEL_W-1:0]   func_sel,
    input  logic [STATE_W-1:0] state_in,
    output logic [STATE_W-1:0] state_out
);

    state_t    x;
    state_t    alpha;
    beta_t     beta;
    state_t    mix_st;
    state_t    inv_st;
    state_t    diff_st;
    state_t    res;
    perm_sel_e mode;

    assign x    = state_t'(state_in);
    assign mode = perm_sel_e'(func_sel);

    perm_pair_xor u_pairs (
        .x     (x),
        .alpha (alpha),
        .beta  (beta)
    );

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        col_t mc;
        col_t ic;
        perm_mix_column #(.COL(c)) u_col (
            .x     (x),
            .alpha (alpha),
            .beta  (beta),
            .mix   (mc),
            .inv   (ic)
        );
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign mix_st[ROWS*c + r] = mc[r];
            assign inv_st[ROWS*c + r] = ic[r];
        end
    end

    perm_binary_diffuse u_diff (
        .x     (x),
        .alpha (alpha),
        .beta  (beta),
        .w     (diff_st)
    );

    always_comb begin
        unique case (mode)
            PERM_MIX:  res = mix_st;
            PERM_INV:  res = inv_st;
            PERM_DIFF: res = diff_st;
            default:   res = x;
        endcase
    end

    assign state_out = STATE_W'(res);

endmodule

// File: rtl/perm_merged_layer_chk.sv
module perm_merged_layer_chk
    import perm_pkg::*;
(
    input logic [SEL_W-1:0]   func_sel,
    input logic [STATE_W-1:0] state_in,
    input logic [STATE_W-1:0] state_out
);

    state_t si;
    state_t so;
    logic   known;
    logic   col_par_ok;
    byte_t  all_in;
    byte_t  all_out;

    assign si    = state_t'(state_in);
    assign so    = state_t'(state_out);
    assign known = !$isunknown(func_sel) && !$isunknown(state_in);

    always_comb begin
        col_par_ok = 1'b1;
        all_in     = '0;
        all_out    = '0;
        for (int c = 0; c < NUM_COLS; c++) begin
            byte_t pi;
            byte_t po;
            pi = '0;
            po = '0;
            for (int r = 0; r < ROWS; r++) begin
                pi = pi ^ si[ROWS*c + r];
                po = po ^ so[ROWS*c + r];
            end
            if (pi != po) col_par_ok = 1'b0;
            all_in  = all_in ^ pi;
            all_out = all_out ^ po;
        end
    end

    always_comb begin
        if (known) begin
            AST_PASS_THROUGH: assert (func_sel != 2'b11 || state_out == state_in) else $error("pass-through altered state"); // R5
            AST_COL_PARITY: assert (func_sel[1] || col_par_ok) else $error("column parity broken"); // R6
            AST_DIFF_PARITY: assert (func_sel != 2'b10 || all_in == all_out) else $error("diffusion parity broken"); // R7
            AST_ZERO_MAP: assert (state_in != '0 || state_out == '0) else $error("zero state not fixed"); // R9
        end
    end

endmodule

bind perm_merged_layer perm_merged_layer_chk u_chk (
    .func_sel  (func_sel),
    .state_in  (state_in),
    .state_out (state_out)
);

// File: tb/perm_merged_layer_bench.sv
module perm_merged_layer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NRAND      = 150;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   func_sel = 2'b00;
    logic [127:0] state_in = '0;
    logic [127:0] state_out;

    int  n_run  = 0;
    int  n_fail = 0;
    int  cycles = 0;
    bit  done   = 0;

    // row k: bit i set when input byte i feeds output byte k
    localparam logic [15:0] DMASK [16] = '{
        16'h6358, 16'h93A4, 16'h9C52, 16'h6CA1,
        16'hC925, 16'hC61A, 16'h3685, 16'h394A,
        16'hA493, 16'h5863, 16'hA16C, 16'h529C,
        16'h1AC6, 16'h25C9, 16'h4A39, 16'h8536};

    perm_merged_layer u_perm_merged_layer (
        .func_sel  (func_sel),
        .state_in  (state_in),
        .state_out (state_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_run  = n_run + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = '0;
        logic [7:0] aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ aa;
            aa = aa[7] ? ((aa << 1) ^ 8'h1B) : (aa << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] gb(logic [127:0] s, int i);
        return s[127 - 8*i -: 8];
    endfunction

    function automatic logic [127:0] model(logic [1:0] sel, logic [127:0] s);
        logic [127:0] o = '0;
        logic [7:0] co [4];
        if (sel == 2'b00) begin
            co = '{8'h02, 8'h03, 8'h01, 8'h01};
        end else begin
            co = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
        end
        for (int k = 0; k < 16; k++) begin
            logic [7:0] acc = '0;
            if (sel == 2'b11) begin
                acc = gb(s, k);
            end else if (sel == 2'b10) begin
                for (int i = 0; i < 16; i++)
                    if (DMASK[k][i]) acc = acc ^ gb(s, i);
            end else begin
                for (int j = 0; j < 4; j++)
                    acc = acc ^ gmul(co[(j - k%4 + 4) % 4], gb(s, 4*(k/4) + j));
            end
            o[127 - 8*k -: 8] = acc;
        end
        return o;
    endfunction

    task automatic run(input logic [1:0] sel, input logic [127:0] s, output logic [127:0] y);
        @(posedge clk);
        #1;
        func_sel = sel;
        state_in = s;
        @(negedge clk);
        y = state_out;
    endtask

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [127:0] y, y2, a, b, ya, yb;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // zero state under every select (R9)
        for (int s = 0; s < 4; s++) begin
            run(2'(s), '0, y);
            chk("R9 zero", y, '0);
        end

        // known column-mix vectors (R1) and their inverse (R2)
        run(2'b00, 128'hdb135345_f20a225c_01010101_2d26314c, y);
        chk("R1 vectors", y, 128'h8e4da1bc_9fdc589d_01010101_4d7ebdf8);
        run(2'b01, 128'h8e4da1bc_9fdc589d_01010101_4d7ebdf8, y);
        chk("R2 vectors", y, 128'hdb135345_f20a225c_01010101_2d26314c);
        run(2'b00, 128'hc6c6c6c6_d4d4d4d5_00000000_ffffffff, y);
        chk("R1 vectors2", y, 128'hc6c6c6c6_d5d5d7d6_00000000_ffffffff);

        // single-bit sweep, every select (R1 R2 R3 R5)
        for (int s = 0; s < 4; s++) begin
            for (int bt = 0; bt < 128; bt++) begin
                logic [127:0] e = 128'd1 << bt;
                run(2'(s), e, y);
                case (s)
                    0: chk("R1 sweep", y, model(2'b00, e));
                    1: chk("R2 sweep", y, model(2'b01, e));
                    2: chk("R3 sweep", y, model(2'b10, e));
                    default: chk("R5 sweep", y, e);
                endcase
            end
        end

        for (int n = 0; n < NRAND; n++) begin
            a = rnd128();
            b = rnd128();
            // R2 round trip
            run(2'b00, a, y);
            chk("R1 random", y, model(2'b00, a));
            run(2'b01, y, y2);
            chk("R2 round trip", y2, a);
            // R4 involution
            run(2'b10, a, y);
            chk("R3 random", y, model(2'b10, a));
            run(2'b10, y, y2);
            chk("R4 involution", y2, a);
            // R6 and R7 parity, checked on output bytes
            for (int s = 0; s < 3; s++) begin
                logic [7:0] pin, pout;
                run(2'(s), a, y);
                if (s < 2) begin
                    for (int c = 0; c < 4; c++) begin
                        pin = gb(a,4*c) ^ gb(a,4*c+1) ^ gb(a,4*c+2) ^ gb(a,4*c+3);
                        pout = gb(y,4*c) ^ gb(y,4*c+1) ^ gb(y,4*c+2) ^ gb(y,4*c+3);
                        chk("R6 column parity", {120'd0, pout}, {120'd0, pin});
                    end
                end else begin
                    pin = '0;
                    pout = '0;
                    for (int i = 0; i < 16; i++) begin
                        pin = pin ^ gb(a, i);
                        pout = pout ^ gb(y, i);
                    end
                    chk("R7 total parity", {120'd0, pout}, {120'd0, pin});
                end
            end
            // R8 column confinement
            for (int s = 0; s < 2; s++) begin
                int c = n % 4;
                logic [127:0] cm = 128'hffffffff << (96 - 32*c);
                run(2'(s), a, ya);
                run(2'(s), a ^ (b & cm), yb);
                chk("R8 confinement", (ya ^ yb) & ~cm, '0);
            end
            // R9 linearity
            for (int s = 0; s < 4; s++) begin
                run(2'(s), a, ya);
                run(2'(s), b, yb);
                run(2'(s), a ^ b, y);
                chk("R9 linearity", y, ya ^ yb);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule